// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block is the configuration-register unit of a power-management function. It holds a 256-byte configuration space reached through dword-addressed, byte-enabled 32-bit writes and reads. Two registers in that space are relocatable I/O base registers. One places a 128-byte window for the power-management register block. The other places a 16-byte window for a two-wire system-bus controller. Each window has its own enable bit, and that bit lives in a separate configuration byte.

The base registers are not plain storage. When written, they drop the address bits below the window size, clear their upper half and force bit 0 to one, and they read back in that form. A write that covers only some byte lanes of a base register merges with the bytes already held before the mask is applied. The second window's enable byte keeps only its low nibble.

An incoming 16-bit I/O address is compared with both windows every cycle. The block raises a combinational hit output for each enabled window that contains the address. The logic behind each window lives outside this block.

Top module: `pm_window_cfg`

## Requirements
- R1: After a synchronous reset, every configuration byte reads zero, except that the dwords at byte offsets 0x48 and 0x90 read 0x00000001. Both hit outputs are low.
- R2: A write with at least one enable lane set to dword index 0x12 (bytes 0x48..0x4B) stores (merged value AND 0x0000FF80) OR 1. Dword 0x12 reads back that value.
- R3: A write with at least one enable lane set to dword index 0x24 (bytes 0x90..0x93) stores (merged value AND 0x0000FFF0) OR 1. Dword 0x24 reads back that value.
- R4: In a base register write, a byte lane whose cfg_be bit is 0 keeps its current byte in the merge. The mask and the forced bit 0 are then applied to the merged value.
- R5: Byte 0x41 (dword 0x10, lane 1) is stored and read back as written. Its bit 7 enables the first window.
- R6: Byte 0xD2 (dword 0x34, lane 2) keeps only its low four bits when written. Its bit 0 enables the second window.
- R7: acpi_hit is 1 exactly when byte 0x41 bit 7 is set and io_addr[15:7] equals the stored base bits [15:7]. This gives a 128-byte window.
- R8: smb_hit is 1 exactly when byte 0xD2 bit 0 is set and io_addr[15:4] equals the stored base bits [15:4]. This gives a 16-byte window.
- R9: Bytes 0x40..0xFF that are not base registers are plain read/write storage. Header bytes 0x00..0x3F always read zero and ignore writes.
- R10: A write takes effect at the rising clock edge on which cfg_wr is 1. cfg_rdata is combinational from cfg_dw and the stored state. While cfg_wr is 0, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index into configuration space (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for writes; lane i is byte 4*cfg_dw+i |
| cfg_wdata | input | 32 | Write data, lane i in bits 8i+7..8i |
| cfg_rdata | output | 32 | Read data of dword cfg_dw |
| io_addr | input | 16 | I/O address to be decoded |
| acpi_hit | output | 1 | io_addr falls in the enabled 128-byte window |
| smb_hit | output | 1 | io_addr falls in the enabled 16-byte window |

## Verification
The bench builds the block with its default parameters: a 256-byte space with a 64-byte header, 16-bit I/O addresses, and window masks of 0xFF80 and 0xFFF0. With these sizes, the exact first and last address of each window and the addresses just outside them can be probed directly. The same sizes let a partial-lane base write cross the mask boundary inside a single byte. A behavioural byte-array model tracks every write and is compared with cfg_rdata and both hit outputs on every clock. Directed checks cover the reset state, mid-run reset and the header bytes.

// File: rtl/pmw_pkg.sv
// Package: shared constants and helpers for the power-management window
// decoder. Assumes a byte-lane width of 8 and four lanes per dword.
package pmw_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;

    typedef logic [LANE_W-1:0] cfg_byte_t;

    // Apply a window mask to a 32-bit base value and force bit 0 high.
    function automatic logic [31:0] shape_base(input logic [31:0] merged,
                                               input logic [31:0] mask32);
        return (merged & mask32) | 32'h1;
    endfunction

endpackage

// File: rtl/pmw_ext_store.sv
// Module: pmw_ext_store
// Byte storage for the configuration space. Bytes below HDR_BYTES are
// constant zero and never written. One byte (KEEP_OFS) stores only the bits
// in KEEP_MASK. Assumes dword-indexed, byte-enabled writes.
module pmw_ext_store #(
    parameter int         CFG_BYTES = 256,
    parameter int         HDR_BYTES = 64,
    parameter int         KEEP_OFS  = 8'hD2,
    parameter logic [7:0] KEEP_MASK = 8'h0F,
    localparam int        DWAW      = $clog2(CFG_BYTES / 4)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [DWAW-1:0]        dw,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    output logic [8*CFG_BYTES-1:0] bytes_o
);

    for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
        localparam logic [DWAW-1:0] MY_DW   = DWAW'(b / 4);
        localparam int              MY_LANE = b % 4;
        if (b < HDR_BYTES) begin : g_hdr
            assign bytes_o[8*b +: 8] = 8'h00;
        end else begin : g_reg
            logic [7:0] q;
            logic       sel;
            assign sel = wr && (dw == MY_DW) && be[MY_LANE];
            // Capture the addressed lane; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 8'h00;
                end else if (sel) begin
                    if (b == KEEP_OFS) q <= wdata[8*MY_LANE +: 8] & KEEP_MASK;
                    else               q <= wdata[8*MY_LANE +: 8];
                end
            end
            assign bytes_o[8*b +: 8] = q;

            if (b == KEEP_OFS) begin : g_keep_chk
                // R6: bits outside the kept nibble never become set.
                p_keep_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    (q & ~KEEP_MASK) == 8'h00);
            end
        end
    end

endmodule

// File: rtl/pmw_base_reg.sv
// Module: pmw_base_reg
// One relocatable base register held at dword index BASE_DW. A write that
// touches any lane merges the enabled lanes with the held value. The result
// is then masked with MASK and bit 0 is forced high. Assumes the register
// is dword aligned.
module pmw_base_reg #(
    parameter int          DWAW    = 6,
    parameter int          IO_AW   = 16,
    parameter int          BASE_DW = 6'h12,
    parameter logic [15:0] MASK    = 16'hFF80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [DWAW-1:0] dw,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [31:0]     value_o,
    output logic [IO_AW-1:0] base_o
);
    import pmw_pkg::*;

    localparam logic [31:0]     MASK32 = 32'(MASK);
    localparam logic [DWAW-1:0] MY_DW  = DWAW'(BASE_DW);

    logic        sel;
    logic [31:0] merged;
    logic [31:0] value_q;

    assign sel = wr && (dw == MY_DW) && (|be);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Choose the new byte for an enabled lane, else keep the held byte.
        assign merged[8*l +: 8] = be[l] ? wdata[8*l +: 8] : value_q[8*l +: 8];
    end

    // Hold the shaped base; reset value is 1 (bit 0 set, base 0).
    always_ff @(posedge clk) begin
        if (!rst_n)   value_q <= 32'h1;
        else if (sel) value_q <= shape_base(merged, MASK32);
    end

    assign value_o = value_q;
    assign base_o  = value_q[IO_AW-1:0];

    // R2/R3: bits outside the mask stay at 0 and bit 0 stays at 1.
    p_low_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (value_q & ~MASK32) == 32'h1);

    // R10: without a selecting write the register holds.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(value_q));

    // R4: a disabled lane 1 keeps its byte through a merge.
    p_merge_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !be[1]) |=> value_q[15:8] == $past(value_q[15:8]));

endmodule

// File: rtl/pmw_window.sv
// Module: pmw_window
// Address comparator for one I/O window. The window is enabled by en. Its
// size is given by the zero low bits of MASK. Assumes base already carries
// the mask.
module pmw_window #(
    parameter int          IO_AW = 16,
    parameter logic [15:0] MASK  = 16'hFF80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IO_AW-1:0] base,
    input  logic [IO_AW-1:0] io_addr,
    output logic             hit
);

    localparam logic [IO_AW-1:0] M = IO_AW'(MASK);

    // Match the upper address bits against the base when enabled.
    always_comb begin
        hit = en && ((io_addr & M) == (base & M));
    end

    // R7/R8: a hit never appears while the window is disabled.
    p_hit_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> en);

endmodule

// File: rtl/pm_window_cfg.sv
// Module: pm_window_cfg
// Configuration unit with two relocatable I/O windows. Writes are
// dword-indexed and byte-enabled, and take effect at the clock edge. Reads
// are combinational. Hit outputs are combinational from io_addr.
module pm_window_cfg #(
    parameter int          CFG_BYTES   = 256,
    parameter int          HDR_BYTES   = 64,
    parameter int          IO_AW       = 16,
    parameter int          ACPI_OFS    = 8'h48,
    parameter logic [15:0] ACPI_MASK   = 16'hFF80,
    parameter int          ACPI_EN_OFS = 8'h41,
    parameter int          ACPI_EN_BIT = 7,
    parameter int          SMB_OFS     = 8'h90,
    parameter logic [15:0] SMB_MASK    = 16'hFFF0,
    parameter int          SMB_EN_OFS  = 8'hD2,
    parameter int          SMB_EN_BIT  = 0,
    parameter logic [7:0]  SMB_EN_KEEP = 8'h0F,
    localparam int         DWAW        = $clog2(CFG_BYTES / 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DWAW-1:0]  cfg_dw,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [IO_AW-1:0] io_addr,
    output logic             acpi_hit,
    output logic             smb_hit
);

    localparam logic [DWAW-1:0] ACPI_DW = DWAW'(ACPI_OFS / 4);
    localparam logic [DWAW-1:0] SMB_DW  = DWAW'(SMB_OFS / 4);

    logic [8*CFG_BYTES-1:0] bytes;
    logic [31:0]            acpi_val, smb_val;
    logic [IO_AW-1:0]       acpi_base, smb_base;
    logic                   acpi_en, smb_en;

    pmw_ext_store #(
        .CFG_BYTES(CFG_BYTES), .HDR_BYTES(HDR_BYTES),
        .KEEP_OFS(SMB_EN_OFS), .KEEP_MASK(SMB_EN_KEEP)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be),
        .wdata(cfg_wdata), .bytes_o(bytes)
    );

    pmw_base_reg #(
        .DWAW(DWAW), .IO_AW(IO_AW), .BASE_DW(ACPI_OFS / 4), .MASK(ACPI_MASK)
    ) u_acpi_base (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be),
        .wdata(cfg_wdata), .value_o(acpi_val), .base_o(acpi_base)
    );

    pmw_base_reg #(
        .DWAW(DWAW), .IO_AW(IO_AW), .BASE_DW(SMB_OFS / 4), .MASK(SMB_MASK)
    ) u_smb_base (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be),
        .wdata(cfg_wdata), .value_o(smb_val), .base_o(smb_base)
    );

    assign acpi_en = bytes[8*ACPI_EN_OFS + ACPI_EN_BIT];
    assign smb_en  = bytes[8*SMB_EN_OFS + SMB_EN_BIT];

    pmw_window #(.IO_AW(IO_AW), .MASK(ACPI_MASK)) u_acpi_win (
        .clk(clk), .rst_n(rst_n), .en(acpi_en), .base(acpi_base),
        .io_addr(io_addr), .hit(acpi_hit)
    );

    pmw_window #(.IO_AW(IO_AW), .MASK(SMB_MASK)) u_smb_win (
        .clk(clk), .rst_n(rst_n), .en(smb_en), .base(smb_base),
        .io_addr(io_addr), .hit(smb_hit)
    );

    // Select the addressed dword: base registers override plain storage.
    always_comb begin
        if (cfg_dw == ACPI_DW)     cfg_rdata = acpi_val;
        else if (cfg_dw == SMB_DW) cfg_rdata = smb_val;
        else                       cfg_rdata = bytes[32*cfg_dw +: 32];
    end

    // R9: a header dword always reads zero.
    p_header_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw < DWAW'(HDR_BYTES / 4)) |-> cfg_rdata == 32'h0);

    // R5: the enable byte changes only through a write to its dword.
    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_dw == DWAW'(ACPI_EN_OFS / 4)) |=> $stable(acpi_en));

endmodule

// File: tb/sim_pm_window_cfg.sv
module sim_pm_window_cfg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        acpi_hit, smb_hit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit model_ok = 1'b0;

    logic [7:0] m [256];

    always #4 clk = ~clk;

    pm_window_cfg u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .acpi_hit(acpi_hit), .smb_hit(smb_hit)
    );

    function automatic logic [31:0] m_rd(input int d);
        return {m[4*d+3], m[4*d+2], m[4*d+1], m[4*d]};
    endfunction

    function automatic logic m_acpi(input logic [15:0] a);
        logic [15:0] b;
        b = {m[8'h49], m[8'h48]};
        return m[8'h41][7] && ((a & 16'hFF80) == (b & 16'hFF80));
    endfunction

    function automatic logic m_smb(input logic [15:0] a);
        logic [15:0] b;
        b = {m[8'h91], m[8'h90]};
        return m[8'hD2][0] && ((a & 16'hFFF0) == (b & 16'hFFF0));
    endfunction

    // Reference model: behavioural byte array updated at each clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m[i] = 8'h00;
            m[8'h48] = 8'h01;
            m[8'h90] = 8'h01;
            model_ok = 1'b1;
        end else if (cfg_wr) begin
            logic [31:0] v;
            for (int l = 0; l < 4; l++)
                if (cfg_be[l] && (4*cfg_dw + l) >= 64)
                    m[4*cfg_dw + l] = cfg_wdata[8*l +: 8];
            if (cfg_dw == 6'h12 && cfg_be != 0) begin
                v = (m_rd(8'h12) & 32'h0000FF80) | 32'h1;
                {m[8'h4B], m[8'h4A], m[8'h49], m[8'h48]} = v;
            end
            if (cfg_dw == 6'h24 && cfg_be != 0) begin
                v = (m_rd(8'h24) & 32'h0000FFF0) | 32'h1;
                {m[8'h93], m[8'h92], m[8'h91], m[8'h90]} = v;
            end
            if (cfg_dw == 6'h34 && cfg_be[2]) m[8'hD2] = m[8'hD2] & 8'h0F;
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every-clock comparison with the model (R10, R7, R8).
    always @(posedge clk) begin
        #2;
        if (rst_n && model_ok && !done) begin
            check("R10 rdata", cfg_rdata, m_rd(cfg_dw));
            check("R7 acpi_hit", 32'(acpi_hit), 32'(m_acpi(io_addr)));
            check("R8 smb_hit", 32'(smb_hit), 32'(m_smb(io_addr)));
        end
    end

    task automatic wr(input logic [5:0] d, input logic [3:0] be,
                      input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = d; cfg_be = be; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] d,
                          input logic [31:0] exp);
        @(negedge clk);
        cfg_dw = d;
        #1 check(req, cfg_rdata, exp);
    endtask

    task automatic hit_chk(input string req, input logic [15:0] a,
                           input logic ea, input logic es);
        @(negedge clk);
        io_addr = a;
        #1;
        check({req, " acpi"}, 32'(acpi_hit), 32'(ea));
        check({req, " smb"},  32'(smb_hit),  32'(es));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd_chk("R1 acpi base", 6'h12, 32'h1);
        rd_chk("R1 smb base",  6'h24, 32'h1);
        rd_chk("R1 byte 0x41", 6'h10, 32'h0);
        rd_chk("R1 byte 0xD2", 6'h34, 32'h0);
        hit_chk("R1 hits", 16'h0000, 1'b0, 1'b0);

        // R2: full ACPI base write.
        wr(6'h12, 4'hF, 32'hDEAD_BEEF);
        rd_chk("R2 acpi base", 6'h12, 32'h0000_BE81);
        hit_chk("R5 disabled", 16'hBE80, 1'b0, 1'b0);

        // R5: enable ACPI window via byte 0x41 bit 7.
        wr(6'h10, 4'b0010, 32'h0000_8500);
        rd_chk("R5 byte 0x41", 6'h10, 32'h0000_8500);
        hit_chk("R7 first", 16'hBE80, 1'b1, 1'b0);
        hit_chk("R7 last",  16'hBEFF, 1'b1, 1'b0);
        hit_chk("R7 above", 16'hBF00, 1'b0, 1'b0);
        hit_chk("R7 below", 16'hBE7F, 1'b0, 1'b0);

        // R4: partial writes merge with held bytes.
        wr(6'h12, 4'b0001, 32'hFFFF_FFC5);
        rd_chk("R4 lane0", 6'h12, 32'h0000_BE81);
        wr(6'h12, 4'b0010, 32'h0000_1200);
        rd_chk("R4 lane1", 6'h12, 32'h0000_1281);
        hit_chk("R4 moved", 16'h12C0, 1'b1, 1'b0);

        // R3: SMB base write.
        wr(6'h24, 4'hF, 32'h1234_567F);
        rd_chk("R3 smb base", 6'h24, 32'h0000_5671);

        // R6: enable byte keeps low nibble.
        wr(6'h34, 4'b0100, 32'h00FF_0000);
        rd_chk("R6 byte 0xD2", 6'h34, 32'h000F_0000);
        hit_chk("R8 first", 16'h5670, 1'b0, 1'b1);
        hit_chk("R8 last",  16'h567F, 1'b0, 1'b1);
        hit_chk("R8 above", 16'h5680, 1'b0, 1'b0);
        hit_chk("R8 below", 16'h566F, 1'b0, 1'b0);
        wr(6'h34, 4'b0100, 32'h00FE_0000);
        rd_chk("R6 nibble", 6'h34, 32'h000E_0000);
        hit_chk("R6 disabled", 16'h5670, 1'b0, 1'b0);

        // R5: clearing bit 7 disables ACPI window.
        wr(6'h10, 4'b0010, 32'h0000_7F00);
        hit_chk("R5 cleared", 16'h12C0, 1'b0, 1'b0);

        // R9: header and plain storage.
        wr(6'h00, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R9 header", 6'h00, 32'h0);
        wr(6'h30, 4'hF, 32'hA5A5_5A5A);
        rd_chk("R9 plain", 6'h30, 32'hA5A5_5A5A);

        // R10: no change without cfg_wr, change only at edge.
        @(negedge clk);
        cfg_wr = 1'b0; cfg_dw = 6'h30; cfg_be = 4'hF; cfg_wdata = 32'h0;
        @(negedge clk);
        #1 check("R10 no wr", cfg_rdata, 32'hA5A5_5A5A);
        cfg_wr = 1'b1; cfg_wdata = 32'h0102_0304;
        #1 check("R10 before edge", cfg_rdata, 32'hA5A5_5A5A);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        #1 check("R10 after edge", cfg_rdata, 32'h0102_0304);

        // R1: mid-run reset.
        do_reset();
        rd_chk("R1 again acpi", 6'h12, 32'h1);
        rd_chk("R1 again plain", 6'h30, 32'h0);
        hit_chk("R1 again hits", 16'h5670, 1'b0, 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule